// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single output-compare channel for a 16-bit timer. It holds a 16-bit compare value that an 8-bit CPU bus writes in two steps. A high-byte write only loads a shared staging latch. A following low-byte write moves the latched high byte and the new low byte together into the compare storage. The stored value is compared against the running counter on every timer clock enable. A match drives a waveform output bit through a 2-bit output mode and sets a sticky match flag.

Double buffering can be turned on. In that case, CPU writes land in a buffer. The buffer is copied into the active compare register only at the selected end of the count, either TOP or BOTTOM. This keeps PWM pulse lengths consistent.

A force strobe moves the output exactly as a match would, without setting the flag. A CPU write to the counter masks the match on the next timer clock enable. The counter itself, the waveform generation mode selection and the pin driver live outside this block and only appear as inputs.

Top module: `ocmp_channel`

## Requirements
- R1: A high-byte write (`wr_hi`) changes only the staging latch; `cmp_active` and `cmp_view` keep their values.
- R2: With `dbuf_en`=0, a low-byte write (`wr_lo`) places {latched high byte, `wdata`} into the active compare register, visible on `cmp_active` after that clock edge.
- R3: With `dbuf_en`=1, a low-byte write goes to the buffer (seen on `cmp_view`). `cmp_active` keeps its value until a cycle with `tick`=1 at the update point: `at_top` when `upd_at_top`=1, or `at_bottom` when `upd_at_top`=0. In that cycle the buffer is copied into the active register.
- R4: A match occurs when `tick`=1, `cnt` equals `cmp_active` and no block is pending. A match sets `match_flag` from the next cycle on. The flag stays set until a cycle with `flag_clr`=1 and no match; a match wins over a clear in the same cycle.
- R5: On a match, `com` selects the output action: 00 leaves `wave_out` unchanged, 01 toggles it, 10 drives it to 0, 11 drives it to 1.
- R6: With `pwm_mode`=0, a `force_cmp` pulse updates `wave_out` as a match would under `com`, and leaves `match_flag` at 0.
- R7: With `pwm_mode`=1, `force_cmp` has no effect on `wave_out`.
- R8: A `cnt_wr` pulse suppresses the match on the next cycle with `tick`=1, however many cycles without `tick` pass in between. Later ticks match normally.
- R9: A new `com` value is used by a match in the same cycle it is applied, with no buffering.
- R10: `wave_out` keeps its value when `pwm_mode` changes.
- R11: After reset, `wave_out`=0, `match_flag`=0, and both the active and buffered compare values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_hi | input | 1 | CPU writes compare high byte |
| wr_lo | input | 1 | CPU writes compare low byte |
| wdata | input | 8 | CPU write data byte |
| dbuf_en | input | 1 | Double buffering of the compare value enabled |
| upd_at_top | input | 1 | Buffer update point: 1 = TOP, 0 = BOTTOM |
| pwm_mode | input | 1 | A PWM waveform mode is selected |
| com | input | 2 | Output action on match |
| force_cmp | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | CPU writes one to clear the match flag |
| tick | input | 1 | Timer clock enable |
| cnt | input | 16 | Current counter value |
| at_top | input | 1 | Counter is at TOP |
| at_bottom | input | 1 | Counter is at BOTTOM |
| cnt_wr | input | 1 | CPU wrote the counter this cycle |
| cmp_active | output | 16 | Active compare value |
| cmp_view | output | 16 | CPU-visible compare value (buffer when double buffered) |
| wave_out | output | 1 | Output compare waveform bit |
| match_flag | output | 1 | Sticky match flag |

## Verification
The bench first writes compare values byte by byte. It checks after each byte, which separates staging-latch behaviour from a real register update. It then applies matching and non-matching counter ticks under each `com` code; toggle, clear, set and hold are told apart by choosing a starting output level that each action would change. Force pulses are issued in both non-PWM and PWM modes to separate a forced update from a real match and from an ignored strobe. A counter write is followed by idle cycles and then a matching tick, to show that the block survives a stopped timer. Finally, double-buffered writes are ticked through both TOP and BOTTOM under each update selection, which shows that only the chosen end loads the active value.

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int BW = 8,
  localparam int W = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [BW-1:0] wdata,
  input  logic          dbuf_en,
  input  logic          upd_at_top,
  input  logic          pwm_mode,
  input  logic [1:0]    com,
  input  logic          force_cmp,
  input  logic          flag_clr,
  input  logic          tick,
  input  logic [W-1:0]  cnt,
  input  logic          at_top,
  input  logic          at_bottom,
  input  logic          cnt_wr,
  output logic [W-1:0]  cmp_active,
  output logic [W-1:0]  cmp_view,
  output logic          wave_out,
  output logic          match_flag
);

  logic [BW-1:0] tmp_hi;
  logic [W-1:0]  buf_q, act_q;
  logic          blk_q, flag_q, wave_q, wave_nxt;

  wire [W-1:0] wr_word = {tmp_hi, wdata};
  wire hit    = tick && (cnt == act_q) && !blk_q;
  wire frc    = force_cmp && !pwm_mode;
  wire upd_pt = dbuf_en && tick && (upd_at_top ? at_top : at_bottom);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmp_hi <= '0;
    else if (wr_hi) tmp_hi <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) buf_q <= '0;
    else if (wr_lo) buf_q <= wr_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) act_q <= '0;
    else if (wr_lo && !dbuf_en) act_q <= wr_word;
    else if (upd_pt) act_q <= buf_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) blk_q <= 1'b0;
    else if (cnt_wr) blk_q <= 1'b1;
    else if (tick) blk_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;

  always_comb
    case (com)
      2'b01:   wave_nxt = ~wave_q;
      2'b10:   wave_nxt = 1'b0;
      2'b11:   wave_nxt = 1'b1;
      default: wave_nxt = wave_q;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wave_q <= 1'b0;
    else if (hit || frc) wave_q <= wave_nxt;

  assign cmp_active = act_q;
  assign cmp_view   = dbuf_en ? buf_q : act_q;
  assign wave_out   = wave_q;
  assign match_flag = flag_q;

  p_hi_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo && !upd_pt) |=> ($stable(act_q) && $stable(buf_q)));

  p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !dbuf_en) |=> (cmp_active == $past(wr_word)));

  p_dbuf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && !upd_pt) |=> $stable(cmp_active));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> match_flag);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !flag_clr) |=> match_flag);

  p_wave_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !frc) |=> $stable(wave_out));

  p_force_noflag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frc && !hit && !match_flag) |=> !match_flag);

  p_pwm_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && force_cmp && !hit) |=> $stable(wave_out));

  p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && !match_flag) |=> !match_flag);

endmodule

// File: tb/test_ocmp_channel.sv
module test_ocmp_channel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_hi = 0, wr_lo = 0, dbuf_en = 0, upd_at_top = 0, pwm_mode = 0;
  logic force_cmp = 0, flag_clr = 0, tick = 0, at_top = 0, at_bottom = 0, cnt_wr = 0;
  logic [7:0] wdata = '0;
  logic [1:0] com = '0;
  logic [15:0] cnt = '0;
  logic [15:0] cmp_active, cmp_view;
  logic wave_out, match_flag;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  ocmp_channel i_ocmp_channel (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clk1();
    @(posedge clk); #1;
  endtask

  task automatic put_hi(input logic [7:0] b);
    wdata = b; wr_hi = 1; clk1(); wr_hi = 0;
  endtask

  task automatic put_lo(input logic [7:0] b);
    wdata = b; wr_lo = 1; clk1(); wr_lo = 0;
  endtask

  task automatic tick_at(input logic [15:0] v, input logic top, input logic bot);
    cnt = v; at_top = top; at_bottom = bot; tick = 1;
    clk1();
    tick = 0; at_top = 0; at_bottom = 0;
  endtask

  task automatic clr_flag();
    flag_clr = 1; clk1(); flag_clr = 0;
  endtask

  task automatic do_force();
    force_cmp = 1; clk1(); force_cmp = 0;
  endtask

  task automatic t_reset();
    chk("R11 wave", {15'd0, wave_out}, 16'd0);
    chk("R11 flag", {15'd0, match_flag}, 16'd0);
    chk("R11 active", cmp_active, 16'd0);
    dbuf_en = 1; #1;
    chk("R11 buffer", cmp_view, 16'd0);
    dbuf_en = 0;
  endtask

  task automatic t_bytes();
    put_hi(8'hA5);
    chk("R1 active", cmp_active, 16'd0);
    chk("R1 view", cmp_view, 16'd0);
    put_lo(8'h3C);
    chk("R2 active", cmp_active, 16'hA53C);
  endtask

  task automatic t_match_flag();
    com = 2'b01;
    tick_at(16'hA53C, 0, 0);
    chk("R4 flag set", {15'd0, match_flag}, 16'd1);
    chk("R5 toggle", {15'd0, wave_out}, 16'd1);
    tick_at(16'h0001, 0, 0);
    chk("R4 flag sticky", {15'd0, match_flag}, 16'd1);
    clr_flag();
    chk("R4 flag clear", {15'd0, match_flag}, 16'd0);
    flag_clr = 1;
    tick_at(16'hA53C, 0, 0);
    flag_clr = 0;
    chk("R4 match beats clear", {15'd0, match_flag}, 16'd1);
    chk("R5 toggle back", {15'd0, wave_out}, 16'd0);
    clr_flag();
  endtask

  task automatic t_modes();
    com = 2'b11; tick_at(16'hA53C, 0, 0);
    chk("R5 R9 set", {15'd0, wave_out}, 16'd1);
    com = 2'b10; tick_at(16'hA53C, 0, 0);
    chk("R5 clear", {15'd0, wave_out}, 16'd0);
    com = 2'b00; tick_at(16'hA53C, 0, 0);
    chk("R5 hold low", {15'd0, wave_out}, 16'd0);
    com = 2'b11; tick_at(16'hA53C, 0, 0);
    com = 2'b00; tick_at(16'hA53C, 0, 0);
    chk("R5 hold high", {15'd0, wave_out}, 16'd1);
    com = 2'b10; tick_at(16'hA53D, 0, 0);
    chk("R4 no match", {15'd0, wave_out}, 16'd1);
    clr_flag();
  endtask

  task automatic t_force();
    pwm_mode = 0; com = 2'b10; do_force();
    chk("R6 force clear", {15'd0, wave_out}, 16'd0);
    com = 2'b11; do_force();
    chk("R6 force set", {15'd0, wave_out}, 16'd1);
    chk("R6 no flag", {15'd0, match_flag}, 16'd0);
    pwm_mode = 1; com = 2'b10; do_force();
    chk("R7 pwm force ignored", {15'd0, wave_out}, 16'd1);
    pwm_mode = 0; clk1();
    chk("R10 mode change keeps wave", {15'd0, wave_out}, 16'd1);
    pwm_mode = 1; clk1();
    chk("R10 mode change back", {15'd0, wave_out}, 16'd1);
    pwm_mode = 0;
  endtask

  task automatic t_block();
    com = 2'b01;
    cnt = 16'hA53C; cnt_wr = 1; clk1(); cnt_wr = 0;
    clk1(); clk1(); clk1();
    tick_at(16'hA53C, 0, 0);
    chk("R8 blocked flag", {15'd0, match_flag}, 16'd0);
    chk("R8 blocked wave", {15'd0, wave_out}, 16'd1);
    tick_at(16'hA53C, 0, 0);
    chk("R8 later match", {15'd0, match_flag}, 16'd1);
    chk("R8 later wave", {15'd0, wave_out}, 16'd0);
    clr_flag();
  endtask

  task automatic t_dbuf();
    com = 2'b00; dbuf_en = 1; upd_at_top = 1;
    put_hi(8'h12); put_lo(8'h34);
    chk("R3 view buffer", cmp_view, 16'h1234);
    chk("R3 active held", cmp_active, 16'hA53C);
    tick_at(16'h0000, 0, 1);
    chk("R3 bottom ignored", cmp_active, 16'hA53C);
    tick_at(16'hFFFF, 1, 0);
    chk("R3 top loads", cmp_active, 16'h1234);
    upd_at_top = 0;
    put_hi(8'h56); put_lo(8'h78);
    tick_at(16'hFFFF, 1, 0);
    chk("R3 top ignored", cmp_active, 16'h1234);
    tick_at(16'h0000, 0, 1);
    chk("R3 bottom loads", cmp_active, 16'h5678);
    dbuf_en = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clk1(); clk1();
    rst_n = 1;
    clk1();
    t_reset();
    t_bytes();
    t_match_flag();
    t_modes();
    t_force();
    t_block();
    t_dbuf();
    finish_run();
  end
endmodule